// File: doc/BRIEF.md
# Bus Address Decoder with Boot Remap and Abort Capture

This block sits in front of the on-chip memories on a 32-bit processor bus. Each cycle it takes the address of the current access and drives one physical select out of three: the non-volatile memory, the SRAM, or the peripheral space. The low address window (the first 1 MB, where the exception vectors live) is an alias. After reset it reaches the non-volatile memory. Software can switch it to reach the SRAM, so that the vectors can be rewritten while the system runs. The non-volatile memory and the SRAM each also have a fixed 1 MB window that the switch does not change. The peripheral space is the top 256 MB of the address range.

The same decode flags faults. A data access whose address is not a multiple of its size aborts, and so does any access that hits no region. When a fault occurs, the block keeps a record of it: the requesting master, a fault code, and the address, size and direction of the access. The record holds the first fault until software reads it. The read clears it. If more faults arrive before the read, an overrun flag is set instead of overwriting the record.

Top module: `bus_front_decoder`

## Requirements
- R1: The decode is combinational, in the same cycle as the access. Addresses with `req_addr[31:20]` equal to 0x001 select the non-volatile memory (`sel` bit 0). Addresses with `req_addr[31:20]` equal to 0x002 select the SRAM (`sel` bit 1). Addresses with `req_addr[31:28]` equal to 0xF select the peripheral space (`sel` bit 2).
- R2: Addresses with `req_addr[31:20]` equal to 0x000 select the non-volatile memory while `remap` is 0, and the SRAM while `remap` is 1. The fixed windows from R1 are not affected by `remap`.
- R3: `remap` inverts on the clock edge after a cycle with `cfg_wr` high and `cfg_wdata` equal to 0xD1. A cfg write with any other value leaves `remap` and the decode unchanged.
- R4: `req_size` encodes the access size: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A data access (`req_fetch`=0) aborts when it is misaligned: a halfword with `req_addr[0]` set, or a word with `req_addr[1:0]` not zero. A byte access is never misaligned.
- R5: An instruction fetch (`req_fetch`=1) is never aborted for alignment.
- R6: An access that matches no region raises `abort`. While `abort` is high, or while `req_valid` is low, `sel` is all zero. A valid access without abort drives exactly one `sel` bit.
- R7: On an aborted access with no record pending, the next cycle shows `stat_valid`=1 with the access's address, size, write flag and master. `stat_code` is 1 for a misaligned access and 2 for an unmapped access; an access that is both is coded 2.
- R8: A pending record stays unchanged until `stat_rd`. After a cycle with `stat_rd` high, `stat_valid` and `stat_overrun` read 0. A fault that arrives while a record is pending sets `stat_overrun` and does not change the record.
- R9: A fault in the same cycle as `stat_rd` is captured as a new record, with `stat_overrun`=0.
- R10: After reset, `remap`, `stat_valid` and `stat_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is present this cycle |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 for a write |
| req_fetch | input | 1 | 1 for an instruction fetch |
| req_master | input | 2 | Identifier of the requesting master |
| sel | output | 3 | One-hot select: bit0 non-volatile memory, bit1 SRAM, bit2 peripherals |
| abort | output | 1 | The current access is aborted |
| cfg_wr | input | 1 | Remap command strobe |
| cfg_wdata | input | 8 | Remap command value |
| remap | output | 1 | Current state of the boot alias |
| stat_rd | input | 1 | Reads and releases the fault record |
| stat_valid | output | 1 | A fault record is pending |
| stat_overrun | output | 1 | Further faults arrived while the record was pending |
| stat_code | output | 2 | 1 misaligned, 2 unmapped |
| stat_addr | output | 32 | Address of the recorded fault |
| stat_size | output | 2 | Size of the recorded fault |
| stat_write | output | 1 | Direction of the recorded fault |
| stat_master | output | 2 | Master of the recorded fault |

## Verification
A wrong remap state shows at once in `sel` on the next access to the low window: the SRAM and non-volatile selects trade places. A flaw in the decode or alignment logic shows in `sel` and `abort` in the same cycle as the access. A fault in the record's update rule shows one cycle after the faulting access, as a wrong `stat_valid` or `stat_overrun`, or as a record field that changed when it should have held.

// File: rtl/bfd_pkg.sv
`timescale 1ns/1ps
package bfd_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        AB_NONE     = 2'd0,
        AB_MISALIGN = 2'd1,
        AB_UNMAPPED = 2'd2
    } abort_code_e;

    localparam int SEL_NVM  = 0;
    localparam int SEL_SRAM = 1;
    localparam int SEL_PERI = 2;
    localparam int N_SEL    = 3;
endpackage

// File: rtl/bfd_region_decode.sv
`timescale 1ns/1ps
module bfd_region_decode #(
    parameter int ADDR_W    = 32,
    parameter int AREA_BITS = 20,
    parameter int PERI_BITS = 28,
    parameter int N_AREA    = 3,
    parameter int BOOT_IDX  = 0,
    parameter int NVM_IDX   = 1,
    parameter int SRAM_IDX  = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    remap,
    output logic [bfd_pkg::N_SEL-1:0] sel_raw,
    output logic                    hit
);
    import bfd_pkg::*;

    localparam int AREA_TAG_W = ADDR_W - AREA_BITS;
    localparam int PERI_TAG_W = ADDR_W - PERI_BITS;

    logic [AREA_TAG_W-1:0] area_tag;
    logic [PERI_TAG_W-1:0] peri_tag;
    logic [N_AREA-1:0]     area_hit;
    logic                  peri_hit;

    assign area_tag = addr[ADDR_W-1:AREA_BITS];
    assign peri_tag = addr[ADDR_W-1:PERI_BITS];

    for (genvar i = 0; i < N_AREA; i++) begin : g_area
        assign area_hit[i] = (area_tag == AREA_TAG_W'(i));
    end

    assign peri_hit = &peri_tag;

    always_comb begin
        sel_raw           = '0;
        sel_raw[SEL_NVM]  = area_hit[NVM_IDX]  | (area_hit[BOOT_IDX] & ~remap);
        sel_raw[SEL_SRAM] = area_hit[SRAM_IDX] | (area_hit[BOOT_IDX] &  remap);
        sel_raw[SEL_PERI] = peri_hit;
        hit               = (|area_hit) | peri_hit;
    end
endmodule

// File: rtl/bfd_align_check.sv
`timescale 1ns/1ps
module bfd_align_check (
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    input  logic       fetch,
    output logic       misalign
);
    import bfd_pkg::*;

    logic bad;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = addr_lo[0];
            SZ_WORD,
            SZ_WIDE: bad = |addr_lo;
            default: bad = 1'b0;
        endcase
        misalign = bad & ~fetch;
    end
endmodule

// File: rtl/bfd_remap_ctl.sv
`timescale 1ns/1ps
module bfd_remap_ctl #(
    parameter int                KEY_W     = 8,
    parameter logic [KEY_W-1:0]  REMAP_KEY = 8'hD1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [KEY_W-1:0] cfg_wdata,
    output logic             remap
);
    typedef struct packed {
        logic remap;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr && (cfg_wdata == REMAP_KEY)) begin
            st_d.remap = ~st_q.remap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remap = st_q.remap;
endmodule

// File: rtl/bfd_abort_record.sv
`timescale 1ns/1ps
module bfd_abort_record #(
    parameter int ADDR_W   = 32,
    parameter int MASTER_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fault,
    input  logic [1:0]          fault_code,
    input  logic [ADDR_W-1:0]   fault_addr,
    input  logic [1:0]          fault_size,
    input  logic                fault_write,
    input  logic [MASTER_W-1:0] fault_master,
    input  logic                stat_rd,
    output logic                stat_valid,
    output logic                stat_overrun,
    output logic [1:0]          stat_code,
    output logic [ADDR_W-1:0]   stat_addr,
    output logic [1:0]          stat_size,
    output logic                stat_write,
    output logic [MASTER_W-1:0] stat_master
);
    typedef struct packed {
        logic                valid;
        logic                overrun;
        logic [1:0]          code;
        logic [ADDR_W-1:0]   addr;
        logic [1:0]          size;
        logic                write;
        logic [MASTER_W-1:0] master;
    } rec_t;

    rec_t rec_d, rec_q;
    logic pending;

    always_comb begin
        rec_d   = rec_q;
        pending = rec_q.valid & ~stat_rd;
        if (stat_rd) begin
            rec_d.valid   = 1'b0;
            rec_d.overrun = 1'b0;
        end
        if (fault) begin
            if (pending) begin
                rec_d.overrun = 1'b1;
            end else begin
                rec_d.valid   = 1'b1;
                rec_d.overrun = 1'b0;
                rec_d.code    = fault_code;
                rec_d.addr    = fault_addr;
                rec_d.size    = fault_size;
                rec_d.write   = fault_write;
                rec_d.master  = fault_master;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign stat_valid   = rec_q.valid;
    assign stat_overrun = rec_q.overrun;
    assign stat_code    = rec_q.code;
    assign stat_addr    = rec_q.addr;
    assign stat_size    = rec_q.size;
    assign stat_write   = rec_q.write;
    assign stat_master  = rec_q.master;
endmodule

// File: rtl/bus_front_decoder.sv
`timescale 1ns/1ps
module bus_front_decoder #(
    parameter int               ADDR_W    = 32,
    parameter int               AREA_BITS = 20,
    parameter int               PERI_BITS = 28,
    parameter int               MASTER_W  = 2,
    parameter int               KEY_W     = 8,
    parameter logic [KEY_W-1:0] REMAP_KEY = 8'hD1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic                req_fetch,
    input  logic [MASTER_W-1:0] req_master,
    output logic [2:0]          sel,
    output logic                abort,
    input  logic                cfg_wr,
    input  logic [KEY_W-1:0]    cfg_wdata,
    output logic                remap,
    input  logic                stat_rd,
    output logic                stat_valid,
    output logic                stat_overrun,
    output logic [1:0]          stat_code,
    output logic [ADDR_W-1:0]   stat_addr,
    output logic [1:0]          stat_size,
    output logic                stat_write,
    output logic [MASTER_W-1:0] stat_master
);
    import bfd_pkg::*;

    logic [N_SEL-1:0] sel_raw;
    logic             hit;
    logic             misalign;
    logic             fault;
    logic [1:0]       fault_code;

    bfd_remap_ctl #(
        .KEY_W     (KEY_W),
        .REMAP_KEY (REMAP_KEY)
    ) u_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .remap     (remap)
    );

    bfd_region_decode #(
        .ADDR_W    (ADDR_W),
        .AREA_BITS (AREA_BITS),
        .PERI_BITS (PERI_BITS)
    ) u_decode (
        .addr    (req_addr),
        .remap   (remap),
        .sel_raw (sel_raw),
        .hit     (hit)
    );

    bfd_align_check u_align (
        .addr_lo  (req_addr[1:0]),
        .size     (req_size),
        .fetch    (req_fetch),
        .misalign (misalign)
    );

    always_comb begin
        fault      = req_valid & (~hit | misalign);
        fault_code = ~hit ? AB_UNMAPPED : AB_MISALIGN;
        abort      = fault;
        sel        = (req_valid && !fault) ? sel_raw : '0;
    end

    bfd_abort_record #(
        .ADDR_W   (ADDR_W),
        .MASTER_W (MASTER_W)
    ) u_record (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault        (fault),
        .fault_code   (fault_code),
        .fault_addr   (req_addr),
        .fault_size   (req_size),
        .fault_write  (req_write),
        .fault_master (req_master),
        .stat_rd      (stat_rd),
        .stat_valid   (stat_valid),
        .stat_overrun (stat_overrun),
        .stat_code    (stat_code),
        .stat_addr    (stat_addr),
        .stat_size    (stat_size),
        .stat_write   (stat_write),
        .stat_master  (stat_master)
    );
endmodule

// File: rtl/bfd_checker.sv
`timescale 1ns/1ps
module bfd_checker #(
    parameter int               ADDR_W    = 32,
    parameter int               AREA_BITS = 20,
    parameter int               MASTER_W  = 2,
    parameter int               KEY_W     = 8,
    parameter logic [KEY_W-1:0] REMAP_KEY = 8'hD1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [1:0]          req_size,
    input logic                req_write,
    input logic                req_fetch,
    input logic [MASTER_W-1:0] req_master,
    input logic [2:0]          sel,
    input logic                abort,
    input logic                cfg_wr,
    input logic [KEY_W-1:0]    cfg_wdata,
    input logic                remap,
    input logic                stat_rd,
    input logic                stat_valid,
    input logic                stat_overrun,
    input logic [1:0]          stat_code,
    input logic [ADDR_W-1:0]   stat_addr,
    input logic [1:0]          stat_size,
    input logic                stat_write,
    input logic [MASTER_W-1:0] stat_master
);
    a_r6_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r6_one_sel_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !abort) |-> ($countones(sel) == 1));

    a_r6_abort_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (abort || !req_valid) |-> (sel == 3'b000));

    a_r3_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr || cfg_wdata != REMAP_KEY) |=> $stable(remap));

    a_r3_key_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata == REMAP_KEY) |=> (remap != $past(remap)));

    a_r5_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch && req_addr[ADDR_W-1:AREA_BITS] == (ADDR_W-AREA_BITS)'(1))
        |-> !abort);

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && (!stat_valid || stat_rd)) |=>
        (stat_valid && !stat_overrun && stat_addr == $past(req_addr)
         && stat_size == $past(req_size) && stat_write == $past(req_write)
         && stat_master == $past(req_master)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_rd) |=>
        (stat_valid && $stable(stat_addr) && $stable(stat_code)));

    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_rd && abort) |=> stat_overrun);

    a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !abort) |=> (!stat_valid && !stat_overrun));
endmodule

bind bus_front_decoder bfd_checker #(
    .ADDR_W    (ADDR_W),
    .AREA_BITS (AREA_BITS),
    .MASTER_W  (MASTER_W),
    .KEY_W     (KEY_W),
    .REMAP_KEY (REMAP_KEY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_write    (req_write),
    .req_fetch    (req_fetch),
    .req_master   (req_master),
    .sel          (sel),
    .abort        (abort),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .remap        (remap),
    .stat_rd      (stat_rd),
    .stat_valid   (stat_valid),
    .stat_overrun (stat_overrun),
    .stat_code    (stat_code),
    .stat_addr    (stat_addr),
    .stat_size    (stat_size),
    .stat_write   (stat_write),
    .stat_master  (stat_master)
);

// File: tb/bus_front_decoder_tb.sv
`timescale 1ns/1ps
module bus_front_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [1:0]  req_master = '0;
    logic [2:0]  sel;
    logic        abort;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        remap;
    logic        stat_rd = 1'b0;
    logic        stat_valid;
    logic        stat_overrun;
    logic [1:0]  stat_code;
    logic [31:0] stat_addr;
    logic [1:0]  stat_size;
    logic        stat_write;
    logic [1:0]  stat_master;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    bus_front_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_fetch(req_fetch),
        .req_master(req_master), .sel(sel), .abort(abort), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .remap(remap), .stat_rd(stat_rd),
        .stat_valid(stat_valid), .stat_overrun(stat_overrun),
        .stat_code(stat_code), .stat_addr(stat_addr), .stat_size(stat_size),
        .stat_write(stat_write), .stat_master(stat_master)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [3:0] model(input logic [31:0] a, input logic [1:0] sz,
                                         input logic f, input logic rm);
        logic [11:0] tag;
        logic [2:0]  s;
        logic        mis;
        tag = a[31:20];
        s   = 3'b000;
        if (a[31:28] == 4'hF)   s = 3'b100;
        else if (tag == 12'h001) s = 3'b001;
        else if (tag == 12'h002) s = 3'b010;
        else if (tag == 12'h000) s = rm ? 3'b010 : 3'b001;
        mis = !f && ((sz == 2'd1 && a[0]) || (sz >= 2'd2 && a[1:0] != 2'b00));
        if (s == 3'b000 || mis) return {1'b1, 3'b000};
        return {1'b0, s};
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
                          input logic f, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        req_write = w; req_fetch = f; req_master = m;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; stat_rd = 1'b0; cfg_wr = 1'b0;
        #1;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b0; cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic read_stat();
        @(negedge clk);
        req_valid = 1'b0; stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        #1;
    endtask

    initial begin
        #800000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [11:0] tags [9];
        logic [3:0]  e;
        tags = '{12'h000, 12'h001, 12'h002, 12'h003, 12'h0FF, 12'h100, 12'hEFF, 12'hF00, 12'hFFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check(remap, 0, "R10 remap after reset");
        check(stat_valid, 0, "R10 stat_valid after reset");
        check(stat_overrun, 0, "R10 stat_overrun after reset");
        idle();
        check(sel, 0, "R6 sel idle");

        // R3: wrong key ignored, visible through decode of the boot window
        cfg_write(8'h5A);
        check(remap, 0, "R3 wrong key ignored");
        access(32'h0000_0040, 2'd2, 1'b0, 1'b0, 2'd0);
        check(sel, 3'b001, "R2 boot window to NVM after bad key");
        idle();

        // R1 R2 R4 R5 R6: sweep both remap states
        for (int rm = 0; rm < 2; rm++) begin
            if (rm == 1) begin
                cfg_write(8'hD1);
                check(remap, 1, "R3 key sets remap");
            end
            for (int t = 0; t < 9; t++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        for (int f = 0; f < 2; f++) begin
                            logic [31:0] a;
                            a = {tags[t], 18'h00A4, 2'(lo)};
                            e = model(a, 2'(sz), f[0], rm[0]);
                            access(a, 2'(sz), lo[0], f[0], 2'(t));
                            check(sel, {29'd0, e[2:0]}, "R1 R2 R6 sel sweep");
                            check(abort, e[3], "R4 R5 R6 abort sweep");
                        end
                    end
                end
            end
            idle();
        end
        cfg_write(8'hD1);
        check(remap, 0, "R3 key clears remap");
        access(32'h0000_0000, 2'd2, 1'b0, 1'b0, 2'd0);
        check(sel, 3'b001, "R2 boot window back to NVM");
        idle();

        // R8: read clears the leftover record
        read_stat();
        check(stat_valid, 0, "R8 read clears valid");
        check(stat_overrun, 0, "R8 read clears overrun");

        // R6 R7: clean access leaves record empty
        access(32'h0010_0004, 2'd2, 1'b1, 1'b0, 2'd1);
        idle();
        check(stat_valid, 0, "R7 no record on good access");

        // R7: misaligned capture
        access(32'h0020_0002, 2'd2, 1'b1, 1'b0, 2'd2);
        idle();
        check(stat_valid, 1, "R7 valid after misalign");
        check(stat_code, 1, "R7 misalign code");
        check(stat_addr, 32'h0020_0002, "R7 addr");
        check(stat_size, 2, "R7 size");
        check(stat_write, 1, "R7 write");
        check(stat_master, 2, "R7 master");
        check(stat_overrun, 0, "R7 no overrun");

        // R8: second fault sets overrun, record kept
        access(32'h0500_0000, 2'd0, 1'b0, 1'b0, 2'd3);
        idle();
        check(stat_overrun, 1, "R8 overrun set");
        check(stat_addr, 32'h0020_0002, "R8 record kept");
        check(stat_code, 1, "R8 code kept");
        read_stat();
        check(stat_valid, 0, "R8 cleared");
        check(stat_overrun, 0, "R8 overrun cleared");

        // R7: unmapped and misaligned codes as unmapped
        access(32'h0300_0001, 2'd1, 1'b0, 1'b0, 2'd1);
        idle();
        check(stat_code, 2, "R7 unmapped wins");
        check(stat_master, 1, "R7 master unmapped");

        // R9: fault coincident with read
        @(negedge clk);
        stat_rd = 1'b1; req_valid = 1'b1; req_addr = 32'h0010_0001;
        req_size = 2'd1; req_write = 1'b0; req_fetch = 1'b0; req_master = 2'd3;
        idle();
        check(stat_valid, 1, "R9 new record valid");
        check(stat_overrun, 0, "R9 no overrun");
        check(stat_addr, 32'h0010_0001, "R9 new addr");
        check(stat_code, 1, "R9 new code");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule